// File: doc/BRIEF.md
# Dual Accumulator Saturation Unit

This unit sits between a 72-bit DSP adder and the two accumulators it feeds, A and B. It takes the adder's 73-bit raw sum, limits it according to the configured saturation mode, and writes it into the selected accumulator. The limit is either the full 72-bit signed range or the 64-bit signed range, in which case the top eight guard bits only carry the sign. An accumulator whose saturation enable is off takes the low 72 bits of the sum unchanged. Its value may then wrap past bit 71 and lose its sign. In that case the unit can raise a one-cycle trap request.

Each accumulator keeps a sticky saturation flag and a guard-overflow flag. Software clears the sticky flags through a clear input. Direct register writes, such as context restores or moves, load an accumulator through a separate port. They skip the saturation logic and leave every flag unchanged. All results are registered: accumulators, flags and the trap request change on the clock edge that samples the write.

Top module: `accsat_unit`

## Requirements
- R1: After reset, both accumulators, both saturation flags, both guard-overflow flags, the combined overflow output and the trap request are zero.
- R2: A DSP write (dsp_we=1) stores into accumulator A when dsp_sel=0 and into B when dsp_sel=1. When no saturation applies, the stored value is dsp_sum[71:0]. The other accumulator is not changed. The result is visible after the sampling clock edge.
- R3: In wide mode (wide_mode=1), with the target's enable set and dsp_sum[72]!=dsp_sum[71], the target is loaded with 0x7F_FFFF_FFFF_FFFF_FFFF when dsp_sum[72]=0 and with 0x80_0000_0000_0000_0000 when dsp_sum[72]=1. The target's saturation flag is set.
- R4: In narrow mode (wide_mode=0), with the target's enable set and dsp_sum[72:63] not all equal, the target is loaded with 0x00_7FFF_FFFF_FFFF_FFFF when dsp_sum[72]=0 and with 0xFF_8000_0000_0000_0000 when dsp_sum[72]=1. The target's saturation flag is set.
- R5: With the target's enable clear, the target takes dsp_sum[71:0] even when that wraps. Its saturation flag is not set.
- R6: On each DSP write, the target's guard-overflow flag is set to 1 when wide_mode=1 and bits 71:63 of the stored value are not all equal. Otherwise it is set to 0, so in narrow mode it is always 0. ovf_any is the OR of both guard-overflow flags.
- R7: trap_req is high for exactly the one cycle after a DSP write in which the target's enable is clear, dsp_sum[72]!=dsp_sum[71] and trap_en=1. It is low after every other cycle.
- R8: Saturation flags stay set until flag_clr=1. flag_clr clears both flags on the next edge and wins over a saturation occurring in the same cycle.
- R9: A direct write (raw_we=1, raw_sel as for dsp_sel) loads raw_data unaltered and leaves all saturation and guard-overflow flags unchanged.
- R10: When a DSP write and a direct write target the same accumulator in the same cycle, the DSP result is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_we | input | 1 | DSP-path write strobe |
| dsp_sel | input | 1 | DSP target: 0 = A, 1 = B |
| dsp_sum | input | W+1 | Raw adder sum, bit W is the carry-out sign |
| raw_we | input | 1 | Direct write strobe |
| raw_sel | input | 1 | Direct target: 0 = A, 1 = B |
| raw_data | input | W | Direct write value |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| wide_mode | input | 1 | 1 = 72-bit limit, 0 = 64-bit limit |
| trap_en | input | 1 | Enables the wrap trap request |
| flag_clr | input | 1 | Clears both saturation flags |
| acc_a | output | W | Accumulator A |
| acc_b | output | W | Accumulator B |
| sat_a | output | 1 | Sticky saturation flag of A |
| sat_b | output | 1 | Sticky saturation flag of B |
| ovf_a | output | 1 | Guard-overflow flag of A |
| ovf_b | output | 1 | Guard-overflow flag of B |
| ovf_any | output | 1 | OR of both guard-overflow flags |
| trap_req | output | 1 | One-cycle arithmetic error trap request |

## Verification
Every result of this unit is due exactly one edge after the stimulus that caused it. This covers the accumulator values, both flag pairs, the combined overflow output and the trap pulse. The driver applies each stimulus on a falling edge and queues the state that the requirements predict. The monitor pops that entry 5 ns after the following rising edge, where it compares all outputs. An idle cycle queued right after a trap-raising write confirms that the pulse has dropped one edge later.

// File: rtl/accsat_unit.sv
module accsat_unit #(
  parameter int W = 72,
  parameter int G = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dsp_we,
  input  logic         dsp_sel,
  input  logic [W:0]   dsp_sum,
  input  logic         raw_we,
  input  logic         raw_sel,
  input  logic [W-1:0] raw_data,
  input  logic         sat_en_a,
  input  logic         sat_en_b,
  input  logic         wide_mode,
  input  logic         trap_en,
  input  logic         flag_clr,
  output logic [W-1:0] acc_a,
  output logic [W-1:0] acc_b,
  output logic         sat_a,
  output logic         sat_b,
  output logic         ovf_a,
  output logic         ovf_b,
  output logic         ovf_any,
  output logic         trap_req
);
  localparam int N = W - G;
  localparam logic [W-1:0] POS_WIDE = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_WIDE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_NAR  = {{(G+1){1'b0}}, {(N-1){1'b1}}};
  localparam logic [W-1:0] NEG_NAR  = {{(G+1){1'b1}}, {(N-1){1'b0}}};

  logic [W-1:0] acc_q [2];
  logic [1:0]   sat_q, ovf_q;
  logic         trap_q;

  wire          wrap    = dsp_sum[W] ^ dsp_sum[W-1];
  wire [G+1:0]  top_sum = dsp_sum[W:N-1];
  wire          nar_ovf = !((&top_sum) || !(|top_sum));
  wire          en      = dsp_sel ? sat_en_b : sat_en_a;
  wire [1:0]    dsel    = {dsp_sel, !dsp_sel} & {2{dsp_we}};
  wire [1:0]    rsel    = {raw_sel, !raw_sel} & {2{raw_we}};

  logic [W-1:0] res;
  logic         hit;

  always_comb begin
    res = dsp_sum[W-1:0];
    hit = 1'b0;
    if (en) begin
      if (wide_mode) begin
        if (wrap) begin
          hit = 1'b1;
          res = dsp_sum[W] ? NEG_WIDE : POS_WIDE;
        end
      end else if (nar_ovf) begin
        hit = 1'b1;
        res = dsp_sum[W] ? NEG_NAR : POS_NAR;
      end
    end
  end

  wire [G:0] top_res = res[W-1:N-1];
  wire       gov     = wide_mode && !((&top_res) || !(|top_res));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q[0] <= '0;
      acc_q[1] <= '0;
      sat_q    <= '0;
      ovf_q    <= '0;
      trap_q   <= 1'b0;
    end else begin
      trap_q <= dsp_we && !en && wrap && trap_en;
      for (int i = 0; i < 2; i++) begin
        if (dsel[i]) begin
          acc_q[i] <= res;
          ovf_q[i] <= gov;
        end else if (rsel[i]) begin
          acc_q[i] <= raw_data;
        end
        if (flag_clr)
          sat_q[i] <= 1'b0;
        else if (dsel[i] && hit)
          sat_q[i] <= 1'b1;
      end
    end
  end

  assign acc_a    = acc_q[0];
  assign acc_b    = acc_q[1];
  assign sat_a    = sat_q[0];
  assign sat_b    = sat_q[1];
  assign ovf_a    = ovf_q[0];
  assign ovf_b    = ovf_q[1];
  assign ovf_any  = |ovf_q;
  assign trap_req = trap_q;
endmodule

// File: rtl/accsat_unit_chk.sv
module accsat_unit_chk #(
  parameter int W = 72,
  parameter int G = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dsp_we,
  input logic         dsp_sel,
  input logic         sat_en_a,
  input logic         wide_mode,
  input logic         trap_en,
  input logic         flag_clr,
  input logic [W-1:0] acc_a,
  input logic         sat_a,
  input logic         sat_b,
  input logic         ovf_a,
  input logic         ovf_b,
  input logic         trap_req
);
  localparam int N = W - G;

  assert_sat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_a && !flag_clr) |=> sat_a);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> (!sat_a && !sat_b));

  assert_narrow_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_we && !dsp_sel && !wide_mode) |=> !ovf_a);

  assert_narrow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_we && !dsp_sel && sat_en_a && !wide_mode) |=>
      ((&acc_a[W-1:N-1]) || !(|acc_a[W-1:N-1])));

  assert_trap_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsp_we && trap_en) |=> !trap_req);

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsp_we && !flag_clr) |=> $stable({sat_a, sat_b, ovf_a, ovf_b}));
endmodule

bind accsat_unit accsat_unit_chk #(.W(W), .G(G)) u_chk (.*);

// File: tb/accsat_unit_tb.sv
module accsat_unit_tb;
  localparam int W = 72;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dsp_we = 0, dsp_sel = 0, raw_we = 0, raw_sel = 0;
  logic [W:0]   dsp_sum = '0;
  logic [W-1:0] raw_data = '0;
  logic         sat_en_a = 0, sat_en_b = 0, wide_mode = 0, trap_en = 0, flag_clr = 0;
  logic [W-1:0] acc_a, acc_b;
  logic         sat_a, sat_b, ovf_a, ovf_b, ovf_any, trap_req;

  always #10 clk = ~clk;

  accsat_unit u_dut (
    .clk(clk), .rst_n(rst_n), .dsp_we(dsp_we), .dsp_sel(dsp_sel), .dsp_sum(dsp_sum),
    .raw_we(raw_we), .raw_sel(raw_sel), .raw_data(raw_data),
    .sat_en_a(sat_en_a), .sat_en_b(sat_en_b), .wide_mode(wide_mode),
    .trap_en(trap_en), .flag_clr(flag_clr),
    .acc_a(acc_a), .acc_b(acc_b), .sat_a(sat_a), .sat_b(sat_b),
    .ovf_a(ovf_a), .ovf_b(ovf_b), .ovf_any(ovf_any), .trap_req(trap_req)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] a, b;
    logic [5:0]   fl;
  } exp_t;

  exp_t         q[$];
  int           checks = 0, errors = 0;
  bit           done = 0;
  logic [W-1:0] m_acc [2];
  logic [1:0]   m_sat = '0, m_ovf = '0;

  task automatic compare(string tag, logic [W-1:0] ea, logic [W-1:0] eb, logic [5:0] ef);
    logic [5:0] af;
    af = {sat_a, sat_b, ovf_a, ovf_b, ovf_any, trap_req};
    checks++;
    if (acc_a !== ea || acc_b !== eb || af !== ef) begin
      errors++;
      $display("FAIL %s: acc_a=%h acc_b=%h flags=%b expected acc_a=%h acc_b=%h flags=%b",
               tag, acc_a, acc_b, af, ea, eb, ef);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(string tag, bit dwe, bit dsl, logic [W:0] s, bit rwe, bit rsl,
                       logic [W-1:0] rd, bit ena, bit enb, bit wide, bit ten, bit clr);
    logic         wrap, nar, en, hit, gov, trap;
    logic [W-1:0] res;
    exp_t         e;
    @(negedge clk);
    dsp_we = dwe; dsp_sel = dsl; dsp_sum = s; raw_we = rwe; raw_sel = rsl; raw_data = rd;
    sat_en_a = ena; sat_en_b = enb; wide_mode = wide; trap_en = ten; flag_clr = clr;
    wrap = s[72] ^ s[71];
    nar  = !((&s[72:63]) || !(|s[72:63]));
    en   = dsl ? enb : ena;
    res  = s[71:0];
    hit  = 0;
    if (en && wide && wrap) begin
      hit = 1; res = s[72] ? 72'h80_0000_0000_0000_0000 : 72'h7F_FFFF_FFFF_FFFF_FFFF;
    end else if (en && !wide && nar) begin
      hit = 1; res = s[72] ? 72'hFF_8000_0000_0000_0000 : 72'h00_7FFF_FFFF_FFFF_FFFF;
    end
    gov  = wide && !((&res[71:63]) || !(|res[71:63]));
    trap = dwe && !en && wrap && ten;
    if (dwe) begin
      m_acc[dsl] = res;
      m_ovf[dsl] = gov;
    end
    if (rwe && !(dwe && rsl == dsl)) m_acc[rsl] = rd;
    if (clr) m_sat = '0;
    else if (dwe && hit) m_sat[dsl] = 1'b1;
    e.tag = tag; e.a = m_acc[0]; e.b = m_acc[1];
    e.fl = {m_sat[0], m_sat[1], m_ovf[0], m_ovf[1], |m_ovf, trap};
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compare(e.tag, e.a, e.b, e.fl);
      end
    end
  end

  initial begin
    #(20 * 5000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    m_acc[0] = '0; m_acc[1] = '0;
    #35;
    compare("R1 reset", '0, '0, 6'b0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #5;
    compare("R1 after release", '0, '0, 6'b0);

    drive("R2 A small", 1, 0, 73'h5, 0, 0, '0, 1, 1, 1, 0, 0);
    drive("R2 B negative", 1, 1, 73'h1_FF_FFFF_FFFF_FFFF_FFFD, 0, 0, '0, 1, 1, 1, 0, 0);
    drive("R3 R6 wide positive", 1, 0, 73'h80_0000_0000_0000_0000, 0, 0, '0, 1, 1, 1, 0, 0);
    drive("R8 R3 clear beats wide negative", 1, 1, 73'h1_00_0000_0000_0000_0001, 0, 0, '0, 1, 1, 1, 0, 1);
    drive("R4 narrow positive", 1, 0, 73'h1_0000_0000_0000_0000, 0, 0, '0, 1, 1, 0, 0, 0);
    drive("R4 narrow negative", 1, 1, 73'h1_FF_0000_0000_0000_0000, 0, 0, '0, 1, 1, 0, 0, 0);
    drive("R9 direct write", 0, 0, '0, 1, 0, 72'h12_3456_789A_BCDE_F012, 1, 1, 1, 0, 0);
    drive("R5 R7 wrap with trap", 1, 0, 73'h80_0000_0000_0000_0000, 0, 0, '0, 0, 1, 1, 1, 0);
    drive("R7 trap drops", 0, 0, '0, 0, 0, '0, 0, 1, 1, 1, 0);
    drive("R7 no trap when disabled", 1, 0, 73'h80_0000_0000_0000_0001, 0, 0, '0, 0, 1, 1, 0, 0);
    drive("R10 DSP beats direct", 1, 0, 73'h77, 1, 0, 72'hAB, 1, 1, 1, 0, 0);
    drive("R8 clear alone", 0, 0, '0, 0, 0, '0, 1, 1, 1, 0, 1);
    drive("R6 guard overflow no sat", 1, 0, 73'h10_0000_0000_0000_0000, 0, 0, '0, 1, 1, 1, 0, 0);
    drive("R5 R6 narrow disabled wraps", 1, 1, 73'h1_0000_0000_0000_0000, 0, 0, '0, 1, 0, 0, 0, 0);
    drive("R9 direct B keeps flags", 0, 0, '0, 1, 1, 72'hFF_FFFF_0000_1111_2222, 1, 1, 1, 0, 0);
    drive("R2 idle", 0, 0, '0, 0, 0, '0, 1, 1, 1, 0, 0);
    repeat (3) @(posedge clk);
    #5;
    finish_run();
  end
endmodule